// File: doc/BRIEF.md
# Classed Control/Status Register Bank

This block holds a small set of memory-mapped registers for one submodule. An upstream bus adapter has already decoded the segment. Each clock cycle it hands the bank one transaction: a kind (idle, read or write), an address and a write-data word. Every register is found through a mask/match descriptor, so one register can also claim a window of addresses.

The bank mixes three register classes. Plain read/write storage is loaded either as a whole word or one bit at a time, and a register may implement only some of its bits. Read-only status words come straight from the hardware. Sticky alarm bits are set by hardware events and cleared by software writing 1. Read data for the addressed register comes out one cycle after a read. All stored values are also driven on dedicated outputs, so the submodule can use them at any time.

Top module: `csr_class_bank`

## Requirements
- R1: Transaction kind encoding on `txn_kind`: 0 = idle, 1 = read, 2 = write, 3 = treated as idle. A register is hit when `(txn_addr & mask) == match`. The default map is: control word at 0x0000, config word at 0x0004, status at 0x0008 and alarm at 0x000C, each with mask 0xFFFF. The bit-write register covers the window 0x0010–0x001F with mask 0xFFF0.
- R2: A write that hits the control word loads all 16 bits of `txn_wdata` into `ctrl_q` at that clock edge.
- R3: A write to address 0x0010+n updates only bit n of `bits_q`, taking its value from `txn_wdata[n]`. All other bits of `bits_q` are unchanged.
- R4: The config word implements only bits 1:0. Bits 15:2 of `cfg_q` and of its read data are always 0, whatever is written.
- R5: A 1 on `alarm_evt[n]` sets bit n of `alarm_q` at the next edge. A write to 0x000C clears each bit of `alarm_q` where `txn_wdata` is 1, and leaves bits where it is 0 unchanged.
- R6: If an event sets an alarm bit in the same cycle that a write-1 clears it, the bit ends up set.
- R7: A read of 0x0008 returns the value of `hw_status` in the read cycle. A write to 0x0008 changes no register.
- R8: A synchronous reset clears `ctrl_q`, `cfg_q`, `bits_q`, `alarm_q` and `rd_data` to 0.
- R9: `rd_data` shows the addressed register's value (taken before that edge's update) one cycle after a read. It is 0 after a read that hits nothing and after any idle or write cycle. Idle and read transactions change no register, whatever their write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| txn_kind | input | 2 | Transaction kind (0 idle, 1 read, 2 write) |
| txn_addr | input | 16 | Transaction byte address |
| txn_wdata | input | 16 | Write data |
| hw_status | input | 16 | Live hardware status word |
| alarm_evt | input | 16 | Per-bit alarm set pulses |
| rd_data | output | 16 | Registered read data |
| ctrl_q | output | 16 | Control word contents |
| cfg_q | output | 16 | Config word contents |
| bits_q | output | 16 | Bit-write register contents |
| alarm_q | output | 16 | Sticky alarm bits |

## Verification
The assertions take for granted that the descriptor map has no overlaps, so at most one register is hit on any address. The bench keeps to the default map, which satisfies this. They also assume `txn_kind`, `txn_addr` and `txn_wdata` are stable across the clock edge. The bench changes them only on the falling edge. Kind 3 is driven on purpose and is expected to behave as idle. `alarm_evt` may be asserted during any transaction, including a write-1 clear of the same bits, because the set-wins rule covers that case.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;

  typedef enum logic [1:0] {
    TXN_IDLE  = 2'd0,
    TXN_READ  = 2'd1,
    TXN_WRITE = 2'd2
  } txn_kind_e;

  localparam int unsigned SLOT_CTRL  = 0;
  localparam int unsigned SLOT_CFG   = 1;
  localparam int unsigned SLOT_STAT  = 2;
  localparam int unsigned SLOT_ALRM  = 3;
  localparam int unsigned SLOT_BITS  = 4;
  localparam int unsigned SLOT_COUNT = 5;

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned SLOTS  = 5,
  parameter logic [SLOTS*ADDR_W-1:0] MASK_VEC  = '0,
  parameter logic [SLOTS*ADDR_W-1:0] MATCH_VEC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  output logic [SLOTS-1:0]  hit
);

  function automatic logic slot_hit(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] m,
                                    input logic [ADDR_W-1:0] v);
    return (a & m) == v;
  endfunction

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam logic [ADDR_W-1:0] M = MASK_VEC[s*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] V = MATCH_VEC[s*ADDR_W +: ADDR_W];
    assign hit[s] = slot_hit(addr, M, V);
  end

  // R1: the map must be disjoint, so one address selects at most one slot
  p_single_hit_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit));

endmodule

// File: rtl/csr_rw_reg.sv
module csr_rw_reg #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned IDX_W     = 4,
  parameter logic [DATA_W-1:0] IMPL = '1,
  parameter bit          BIT_MODE  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);

  localparam logic [DATA_W-1:0] LSB_ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  function automatic logic [DATA_W-1:0] bit_merge(input logic [DATA_W-1:0] old,
                                                  input logic [DATA_W-1:0] d,
                                                  input logic [IDX_W-1:0] idx);
    logic [DATA_W-1:0] sel;
    sel = LSB_ONE << idx;
    return (old & ~sel) | (d & sel);
  endfunction

  logic [DATA_W-1:0] load_val;

  if (BIT_MODE) begin : g_bitwise
    assign load_val = bit_merge(q, wdata, bit_idx);
    // R3: only the addressed bit may move on a write
    p_bit_only_r3: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> ((q ^ $past(q)) & ~(LSB_ONE << $past(bit_idx))) == '0);
  end else begin : g_word
    assign load_val = wdata;
    // R2: a word write lands in full (within implemented bits)
    p_word_load_r2: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> q == ($past(wdata) & IMPL));
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (wr_en) q <= load_val & IMPL;
    else q <= q & IMPL;
  end

  // R4: unimplemented bits never hold a 1
  p_unimpl_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (q & ~IMPL) == '0);

  // R9: without a write the contents hold
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(q));

endmodule

// File: rtl/csr_w1c_reg.sv
module csr_w1c_reg #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] set_evt,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] clr_mask,
  output logic [DATA_W-1:0] q
);

  function automatic logic [DATA_W-1:0] sticky_next(input logic [DATA_W-1:0] cur,
                                                    input logic [DATA_W-1:0] set,
                                                    input logic [DATA_W-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  logic [DATA_W-1:0] clr_eff;
  assign clr_eff = clr_en ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else q <= sticky_next(q, set_evt, clr_eff);
  end

  // R6: an event always leaves its bit set
  p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (|set_evt) |=> (q & $past(set_evt)) == $past(set_evt));

  // R5: write-1 clears the selected bits that had no event
  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> (q & $past(clr_mask) & ~$past(set_evt)) == '0);

  // R5: with no event and no clear the bits hold
  p_sticky_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!clr_en && set_evt == '0) |=> $stable(q));

endmodule

// File: rtl/csr_class_bank.sv
module csr_class_bank #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h0000,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 16'h0004,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h0008,
  parameter logic [ADDR_W-1:0] ALRM_ADDR = 16'h000C,
  parameter logic [ADDR_W-1:0] BITS_BASE = 16'h0010,
  parameter logic [DATA_W-1:0] CFG_IMPL  = 16'h0003
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        txn_kind,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic [DATA_W-1:0] txn_wdata,
  input  logic [DATA_W-1:0] hw_status,
  input  logic [DATA_W-1:0] alarm_evt,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] cfg_q,
  output logic [DATA_W-1:0] bits_q,
  output logic [DATA_W-1:0] alarm_q
);
  import csr_bank_pkg::*;

  localparam int unsigned SLOTS = SLOT_COUNT;
  localparam int unsigned IDX_W = $clog2(DATA_W);
  localparam logic [ADDR_W-1:0] FULL_MASK = '1;
  localparam logic [ADDR_W-1:0] BITS_MASK = FULL_MASK << IDX_W;
  localparam logic [SLOTS*ADDR_W-1:0] MASK_VEC =
    {BITS_MASK, FULL_MASK, FULL_MASK, FULL_MASK, FULL_MASK};
  localparam logic [SLOTS*ADDR_W-1:0] MATCH_VEC =
    {BITS_BASE, ALRM_ADDR, STAT_ADDR, CFG_ADDR, CTRL_ADDR};

  txn_kind_e         kind;
  logic              is_rd;
  logic              is_wr;
  logic [SLOTS-1:0]  hit;
  logic [SLOTS-1:0]  wr_hit;
  logic [DATA_W-1:0] slot_val [SLOTS];
  logic [DATA_W-1:0] rd_mux;

  assign kind   = txn_kind_e'(txn_kind);
  assign is_rd  = (kind == TXN_READ);
  assign is_wr  = (kind == TXN_WRITE);
  assign wr_hit = hit & {SLOTS{is_wr}};

  csr_addr_decode #(
    .ADDR_W(ADDR_W), .SLOTS(SLOTS),
    .MASK_VEC(MASK_VEC), .MATCH_VEC(MATCH_VEC)
  ) dec_i (
    .clk(clk), .rst(rst), .addr(txn_addr), .hit(hit)
  );

  csr_rw_reg #(.DATA_W(DATA_W), .IDX_W(IDX_W), .IMPL('1), .BIT_MODE(1'b0)) ctrl_i (
    .clk(clk), .rst(rst), .wr_en(wr_hit[SLOT_CTRL]),
    .bit_idx(txn_addr[IDX_W-1:0]), .wdata(txn_wdata), .q(ctrl_q)
  );

  csr_rw_reg #(.DATA_W(DATA_W), .IDX_W(IDX_W), .IMPL(CFG_IMPL), .BIT_MODE(1'b0)) cfg_i (
    .clk(clk), .rst(rst), .wr_en(wr_hit[SLOT_CFG]),
    .bit_idx(txn_addr[IDX_W-1:0]), .wdata(txn_wdata), .q(cfg_q)
  );

  csr_rw_reg #(.DATA_W(DATA_W), .IDX_W(IDX_W), .IMPL('1), .BIT_MODE(1'b1)) bits_i (
    .clk(clk), .rst(rst), .wr_en(wr_hit[SLOT_BITS]),
    .bit_idx(txn_addr[IDX_W-1:0]), .wdata(txn_wdata), .q(bits_q)
  );

  csr_w1c_reg #(.DATA_W(DATA_W)) alrm_i (
    .clk(clk), .rst(rst), .set_evt(alarm_evt),
    .clr_en(wr_hit[SLOT_ALRM]), .clr_mask(txn_wdata), .q(alarm_q)
  );

  assign slot_val[SLOT_CTRL] = ctrl_q;
  assign slot_val[SLOT_CFG]  = cfg_q;
  assign slot_val[SLOT_STAT] = hw_status;
  assign slot_val[SLOT_ALRM] = alarm_q;
  assign slot_val[SLOT_BITS] = bits_q;

  always_comb begin
    rd_mux = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (hit[s]) rd_mux = rd_mux | slot_val[s];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (is_rd) rd_data <= rd_mux;
    else rd_data <= '0;
  end

  // R9: only a read cycle produces nonzero read data
  p_quiet_bus_r9: assert property (@(posedge clk) disable iff (rst)
    !is_rd |=> rd_data == '0);

  // R7: a status read returns the live hardware word
  p_status_read_r7: assert property (@(posedge clk) disable iff (rst)
    (is_rd && hit[SLOT_STAT]) |=> rd_data == $past(hw_status));

  // R7: a write to the status slot moves no stored register
  p_status_nowrite_r7: assert property (@(posedge clk) disable iff (rst)
    (is_wr && hit[SLOT_STAT]) |=> $stable(ctrl_q) && $stable(cfg_q) && $stable(bits_q));

endmodule

// File: tb/csr_class_bank_tb_top.sv
`timescale 1ns/1ps
module csr_class_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  txn_kind = 2'd0;
  logic [15:0] txn_addr = '0;
  logic [15:0] txn_wdata = '0;
  logic [15:0] hw_status = '0;
  logic [15:0] alarm_evt = '0;
  logic [15:0] rd_data, ctrl_q, cfg_q, bits_q, alarm_q;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [15:0] m_ctrl = '0, m_cfg = '0, m_bits = '0, m_alrm = '0;

  always #2 clk = ~clk;

  csr_class_bank dut_i (
    .clk(clk), .rst(rst), .txn_kind(txn_kind), .txn_addr(txn_addr),
    .txn_wdata(txn_wdata), .hw_status(hw_status), .alarm_evt(alarm_evt),
    .rd_data(rd_data), .ctrl_q(ctrl_q), .cfg_q(cfg_q),
    .bits_q(bits_q), .alarm_q(alarm_q)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(input logic [15:0] a);
    if (a == 16'h0000) return m_ctrl;
    if (a == 16'h0004) return m_cfg;
    if (a == 16'h0008) return hw_status;
    if (a == 16'h000C) return m_alrm;
    if (a[15:4] == 12'h001) return m_bits;
    return 16'h0000;
  endfunction

  task automatic check_all(input string req, input logic [15:0] exp_rd);
    chk(req, "rd_data", rd_data, exp_rd);
    chk(req, "ctrl_q", ctrl_q, m_ctrl);
    chk(req, "cfg_q", cfg_q, m_cfg);
    chk(req, "bits_q", bits_q, m_bits);
    chk(req, "alarm_q", alarm_q, m_alrm);
  endtask

  // drive at a falling edge, one rising edge, check at the next falling edge
  task automatic txn(input string req, input logic [1:0] k, input logic [15:0] a,
                     input logic [15:0] d, input logic [15:0] evt);
    logic [15:0] exp_rd;
    logic [15:0] clr;
    txn_kind = k; txn_addr = a; txn_wdata = d; alarm_evt = evt;
    exp_rd = (k == 2'd1) ? exp_read(a) : 16'h0000;
    clr = '0;
    if (k == 2'd2) begin
      if (a == 16'h0000) m_ctrl = d;
      if (a == 16'h0004) m_cfg = d & 16'h0003;
      if (a == 16'h000C) clr = d;
      if (a[15:4] == 12'h001) m_bits[a[3:0]] = d[a[3:0]];
    end
    m_alrm = (m_alrm & ~clr) | evt;
    @(posedge clk);
    @(negedge clk);
    check_all(req, exp_rd);
  endtask

  task automatic do_reset();
    rst = 1'b1; txn_kind = 2'd0; alarm_evt = '0;
    repeat (2) begin @(posedge clk); @(negedge clk); end
    rst = 1'b0;
    m_ctrl = '0; m_cfg = '0; m_bits = '0; m_alrm = '0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    check_all("R8", 16'h0000);

    // R2: whole-word loads of several patterns, read back
    foreach (m_ctrl[i]) begin
      txn("R2", 2'd2, 16'h0000, 16'h1 << i ^ 16'hA5C3, 16'h0);
      txn("R2", 2'd1, 16'h0000, 16'h0, 16'h0);
    end

    // R4: config keeps only bits 1:0
    for (int v = 0; v < 16; v++) begin
      txn("R4", 2'd2, 16'h0004, 16'hFFF0 | 16'(v) | 16'(v << 9), 16'h0);
      txn("R4", 2'd1, 16'h0004, 16'h0, 16'h0);
    end

    // R3: set every bit via its own address with all-ones data, then clear evens
    for (int n = 0; n < 16; n++) txn("R3", 2'd2, 16'h0010 + 16'(n), 16'hFFFF, 16'h0);
    for (int n = 0; n < 16; n += 2) txn("R3", 2'd2, 16'h0010 + 16'(n), 16'h0000, 16'h0);
    for (int n = 0; n < 16; n++) txn("R3", 2'd1, 16'h0010 + 16'(n), 16'h0, 16'h0);
    for (int n = 0; n < 16; n++) txn("R3", 2'd2, 16'h0010 + 16'(n), ~(16'h1 << n), 16'h0);

    // R7: status read follows hw_status, writes change nothing
    for (int p = 0; p < 8; p++) begin
      hw_status = 16'h1357 * 16'(p + 1);
      txn("R7", 2'd1, 16'h0008, 16'h0, 16'h0);
      txn("R7", 2'd2, 16'h0008, 16'hFFFF, 16'h0);
    end

    // R5: plain set then write-1 clear
    txn("R5", 2'd0, 16'h0000, 16'h0, 16'hF0F0);
    txn("R5", 2'd1, 16'h000C, 16'h0, 16'h0);
    txn("R5", 2'd2, 16'h000C, 16'h3030, 16'h0);
    txn("R5", 2'd2, 16'h000C, 16'hFFFF, 16'h0);

    // R6: exhaustive low-nibble set/clear combinations
    for (int s = 0; s < 16; s++) begin
      for (int c = 0; c < 16; c++) begin
        txn("R6", 2'd0, 16'h0000, 16'h0, 16'h000F);
        txn("R6", 2'd2, 16'h000C, 16'(c), 16'(s));
        txn("R6", 2'd2, 16'h000C, 16'hFFFF, 16'h0);
      end
    end

    // R9: idle, read and kind 3 with write data change nothing
    txn("R9", 2'd2, 16'h0000, 16'h5A5A, 16'h0);
    txn("R9", 2'd0, 16'h0000, 16'hFFFF, 16'h0);
    txn("R9", 2'd1, 16'h0000, 16'h0F0F, 16'h0);
    txn("R9", 2'd3, 16'h0000, 16'h1234, 16'h0);
    txn("R9", 2'd3, 16'h000C, 16'hFFFF, 16'h0);

    // R1: address sweep, hits and misses
    txn("R1", 2'd0, 16'h0000, 16'h0, 16'h0081);
    hw_status = 16'hBEEF;
    for (int a = 0; a < 64; a++) txn("R1", 2'd1, 16'(a), 16'h0, 16'h0);
    txn("R1", 2'd1, 16'h0100, 16'h0, 16'h0);
    txn("R1", 2'd1, 16'hFFFF, 16'h0, 16'h0);
    txn("R1", 2'd2, 16'h8004, 16'hFFFF, 16'h0);

    // R8: reset with everything loaded
    txn("R8", 2'd2, 16'h0004, 16'h0003, 16'hFFFF);
    do_reset();
    check_all("R8", 16'h0000);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule